// File: doc/BRIEF.md
# Serial register-access slave port

This block is the slave side of a four-wire serial control link. It gives a host access to an on-chip register space with a 13-bit address. Each access begins with a 16-bit instruction word. The word gives the direction, a transfer length and a starting address. One, two or three data bytes follow, or an open-ended stream that lasts until chip select is released.

Write bytes come out on the internal side as single-cycle write strobes with an address and a byte. Read bytes are fetched with single-cycle read requests; the register space returns the byte in the same cycle. The fetched byte is then shifted out on the data-out line.

Bits can travel most-significant first or least-significant first. The bit order also decides which way the address steps from byte to byte. The bit order is chosen by writing bit 6 of register 0x0000. The host may release chip select between whole bytes to pause a transfer. Releasing it in the middle of a byte abandons the access.

The port runs on a fast system clock. It samples the serial pins through a synchronizer and acts on the SCLK edges it detects. SCLK must therefore stay at each level for several system clock cycles.

Top module: `spi_regport`

## Requirements
- R1: The instruction word has 16 bits. Bit 15 selects a read when 1 and a write when 0. Bits 14:13 give the length: 00 is one byte, 01 is two bytes, 10 is three bytes and 11 streams until chip select rises. Bits 12:0 are the first register address. A read instruction never produces a write strobe.
- R2: Serial input bits are taken on rising SCLK edges. Each complete write data byte produces exactly one single-cycle `reg_wr` pulse, with `reg_addr` and `reg_wdata` valid in that cycle.
- R3: Each read data byte is fetched with a single-cycle `reg_rd` pulse on `reg_addr`, and `reg_rdata` is taken in that same cycle. The byte's bits appear on `sdo`, and `sdo` changes only after falling SCLK edges. `sdo_oe` is high only during the read data phase while chip select is low. `sdo` is 0 whenever `sdo_oe` is low.
- R4: In most-significant-first mode, the instruction is received bit 15 first and each data byte bit 7 first. The address decrements after every data byte and wraps from 0x0000 to 0x1FFF.
- R5: In least-significant-first mode, the instruction is received bit 0 first and each data byte bit 0 first. The address increments after every data byte and wraps from 0x1FFF to 0x0000.
- R6: After reset the port is in most-significant-first mode. A write byte to address 0x0000 sets least-significant-first mode when its bit 6 is 1 and clears it when bit 6 is 0. The new mode applies from the next instruction, not to later bytes of the same transfer.
- R7: After the number of bytes set by the length field, further SCLK edges produce no strobes and `sdo_oe` stays low until chip select rises. A streaming transfer runs until chip select rises. A streaming read may request one address beyond the last byte shifted out.
- R8: In a non-streaming transfer, releasing chip select after a whole byte pauses the transfer, and the transfer continues when chip select falls again. A final rising edge of SCLK that arrives in the same cycle as the chip-select release still completes its byte.
- R9: Releasing chip select while a byte or the instruction is only partly shifted returns the port to the instruction phase. The partial byte gives no strobe.
- R10: During and after reset, `reg_wr`, `reg_rd`, `sdo` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | High while `sdo` should be driven onto the pad |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read request |
| reg_addr | output | 13 | Register address for `reg_wr` or `reg_rd` |
| reg_wdata | output | 8 | Write byte, valid with `reg_wr` |
| reg_rdata | input | 8 | Read byte, returned in the cycle of `reg_rd` |

## Verification
Two things can happen in the same system cycle: the last rising SCLK edge of a byte, and the release of chip select. When that byte is also a write to address 0x0000, a mode change lands in that cycle as well. The bench raises SCLK and chip select in the same timestep at the end of a one-byte write to address 0x0000 that clears bit 6. It passes if the write strobe still appears with the right address and data, and if the next transfer is decoded most-significant first with decrementing addresses. Sweeps over every length code, both bit orders and start addresses next to the wrap points cover the address stepping. Paused, aborted and over-long transfers are also checked.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int unsigned REG_AW  = 13;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LEN_W   = 2;
    localparam int unsigned INSTR_W = 1 + LEN_W + REG_AW;
    localparam int unsigned CNT_W   = $clog2(INSTR_W);
    localparam int unsigned BIT_W   = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_INSTR = 2'd0,
        ST_WR    = 2'd1,
        ST_RD    = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    typedef struct packed {
        st_e                 st;
        logic [CNT_W-1:0]    cnt;
        logic [INSTR_W-1:0]  instr;
        logic [BYTE_W-1:0]   sh;
        logic [REG_AW-1:0]   addr;
        logic [LEN_W-1:0]    left;
        logic                stream;
        logic                lsb;
        logic                lsb_pend;
        logic                wr;
        logic                rd;
        logic [REG_AW-1:0]   aout;
        logic [BYTE_W-1:0]   wdata;
        logic                sdo;
        logic                sclk_prev;
        logic                csn_prev;
    } port_s;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (STAGES == 0) begin : g_bypass
        assign q_o = d_i;
    end else begin : g_chain
        logic [W-1:0] stg_q [STAGES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
                stg_q[0] <= d_i;
                for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
        end

        assign q_o = stg_q[STAGES-1];
    end

endmodule

// File: rtl/spi_regport_shin.sv
module spi_regport_shin #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_i,
    input  logic         bit_i,
    input  logic         lsb_i,
    output logic [W-1:0] vec_o
);

    // First-arriving bit ends up at bit 0 when lsb_i, at bit W-1 otherwise.
    assign vec_o = lsb_i ? {bit_i, vec_i[W-1:1]} : {vec_i[W-2:0], bit_i};

endmodule

// File: rtl/spi_regport_step.sv
module spi_regport_step #(
    parameter int unsigned AW = 13
) (
    input  logic [AW-1:0] addr_i,
    input  logic          up_i,
    output logic [AW-1:0] addr_o
);

    // Modulo-2^AW stepping; no address is ever skipped.
    assign addr_o = up_i ? addr_i + AW'(1) : addr_i - AW'(1);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [REG_AW-1:0] MODE_ADDR = '0,
    parameter int unsigned MODE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [BIT_W-1:0] BYTE_LAST  = BIT_W'(BYTE_W - 1);

    port_s q, n;

    logic sclk_s, csn_s, sdi_s;
    logic [INSTR_W-1:0] instr_nx;
    logic [BYTE_W-1:0]  data_nx;
    logic [REG_AW-1:0]  addr_step;
    logic [BIT_W-1:0]   out_idx;
    st_e                st_q;

    spi_regport_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk, cs_n, sdi}),
        .q_o   ({sclk_s, csn_s, sdi_s})
    );

    spi_regport_shin #(.W(INSTR_W)) u_shin_instr (
        .vec_i (q.instr),
        .bit_i (sdi_s),
        .lsb_i (q.lsb),
        .vec_o (instr_nx)
    );

    spi_regport_shin #(.W(BYTE_W)) u_shin_data (
        .vec_i (q.sh),
        .bit_i (sdi_s),
        .lsb_i (q.lsb),
        .vec_o (data_nx)
    );

    spi_regport_step #(.AW(REG_AW)) u_step (
        .addr_i (q.addr),
        .up_i   (q.lsb),
        .addr_o (addr_step)
    );

    assign out_idx = q.lsb ? q.cnt[BIT_W-1:0] : BYTE_LAST - q.cnt[BIT_W-1:0];
    assign st_q    = q.st;

    always_comb begin
        logic rise, fall;
        n           = q;
        n.wr        = 1'b0;
        n.rd        = 1'b0;
        n.sclk_prev = sclk_s;
        n.csn_prev  = csn_s;
        rise        = sclk_s & ~q.sclk_prev;
        fall        = ~sclk_s & q.sclk_prev;

        // Byte returned by the register space in the request cycle.
        if (q.rd) n.sh = reg_rdata;

        // Rising edge counts only if chip select was low before it.
        if (rise && !q.csn_prev) begin
            unique case (q.st)
                ST_INSTR: begin
                    n.instr = instr_nx;
                    n.cnt   = q.cnt + CNT_W'(1);
                    if (q.cnt == INSTR_LAST) begin
                        n.cnt    = '0;
                        n.addr   = instr_nx[REG_AW-1:0];
                        n.left   = instr_nx[INSTR_W-2 -: LEN_W];
                        n.stream = &instr_nx[INSTR_W-2 -: LEN_W];
                        if (instr_nx[INSTR_W-1]) begin
                            n.st   = ST_RD;
                            n.rd   = 1'b1;
                            n.aout = instr_nx[REG_AW-1:0];
                        end else begin
                            n.st = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    n.sh  = data_nx;
                    n.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt[BIT_W-1:0] == BYTE_LAST) begin
                        n.cnt   = '0;
                        n.wr    = 1'b1;
                        n.aout  = q.addr;
                        n.wdata = data_nx;
                        n.addr  = addr_step;
                        if (q.addr == MODE_ADDR) n.lsb_pend = data_nx[MODE_BIT];
                        if (!q.stream) begin
                            if (q.left == '0) n.st = ST_DONE;
                            else              n.left = q.left - LEN_W'(1);
                        end
                    end
                end
                ST_RD: begin
                    n.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt[BIT_W-1:0] == BYTE_LAST) begin
                        n.cnt  = '0;
                        n.addr = addr_step;
                        if (!q.stream && q.left == '0) begin
                            n.st = ST_DONE;
                        end else begin
                            if (!q.stream) n.left = q.left - LEN_W'(1);
                            n.rd   = 1'b1;
                            n.aout = addr_step;
                        end
                    end
                end
                default: ;
            endcase
        end

        // Read data changes only after falling edges.
        if (fall && q.st == ST_RD) n.sdo = q.sh[out_idx];

        // Chip select released: pause at a boundary, otherwise end.
        if (csn_s) begin
            if (n.cnt[BIT_W-1:0] != '0 || n.st == ST_DONE ||
                (n.stream && n.st != ST_INSTR)) begin
                n.st     = ST_INSTR;
                n.cnt    = '0;
                n.stream = 1'b0;
            end
            if (n.st == ST_INSTR && n.cnt == '0) n.lsb = n.lsb_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.csn_prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign reg_wr    = q.wr;
    assign reg_rd    = q.rd;
    assign reg_addr  = q.aout;
    assign reg_wdata = q.wdata;
    assign sdo_oe    = (q.st == ST_RD) && !csn_s;
    assign sdo       = sdo_oe & q.sdo;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_rd,
    input logic sdo,
    input logic sdo_oe,
    input st_e  st
);

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R3
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> st == ST_RD);

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && $past(st) == ST_DONE) |-> (!reg_wr && !reg_rd && !sdo_oe));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_INSTR |-> (!sdo_oe && !sdo));

endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_wr (reg_wr),
    .reg_rd (reg_rd),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .st     (st_q)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;

    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, reg_wr, reg_rd;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic oe_s;

    logic [12:0] wa [256];
    logic [7:0]  wd [256];
    logic [12:0] ra [256];
    int wn = 0;
    int rn = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    function automatic logic [12:0] ea(input logic [12:0] s, input int k, input logic lsb);
        return lsb ? s + 13'(k) : s - 13'(k);
    endfunction

    // Bit 6 equals the current mode so address 0x0000 keeps the mode.
    function automatic logic [7:0] dat(input int k, input logic [12:0] s, input logic lsb);
        logic [2:0] kk;
        kk = 3'(k);
        return {1'b1, lsb, kk ^ s[2:0], s[5:3]};
    endfunction

    assign reg_rdata = pat(reg_addr);

    spi_regport uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always @(negedge clk) begin
        if (reg_wr) begin
            wa[wn % 256] = reg_addr;
            wd[wn % 256] = reg_wdata;
            wn = wn + 1;
        end
        if (reg_rd) begin
            ra[rn % 256] = reg_addr;
            rn = rn + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sdi = b;
        wait_clk(HP);
        r = sdo;
        oe_s = sdo_oe;
        sclk = 1'b1;
        wait_clk(HP);
        sclk = 1'b0;
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_hi();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic lsb);
        logic r;
        for (int i = 0; i < 8; i++) xbit(lsb ? v[i] : v[7-i], r);
    endtask

    task automatic recv_byte(input logic lsb, output logic [7:0] v);
        logic r;
        for (int i = 0; i < 8; i++) begin
            xbit(1'b0, r);
            if (lsb) v[i] = r;
            else     v[7-i] = r;
        end
    endtask

    task automatic send_instr(input logic [15:0] w, input logic lsb);
        logic r;
        for (int i = 0; i < 16; i++) xbit(lsb ? w[i] : w[15-i], r);
    endtask

    // Last rising SCLK edge and chip-select release in the same timestep.
    task automatic send_byte_end(input logic [7:0] v, input logic lsb);
        logic r;
        for (int i = 0; i < 7; i++) xbit(lsb ? v[i] : v[7-i], r);
        sdi = lsb ? v[7] : v[0];
        wait_clk(HP);
        sclk = 1'b1;
        cs_n = 1'b1;
        wait_clk(HP);
        sclk = 1'b0;
        wait_clk(4 * HP);
    endtask

    task automatic do_write(input logic [12:0] s, input int len, input logic lsb, input bit stall);
        int nb, ns, base;
        nb = (len == 3) ? 5 : len + 1;
        ns = (stall || len == 3) ? nb : nb + 1;
        base = wn;
        cs_lo();
        send_instr({1'b0, 2'(len), s}, lsb);
        for (int k = 0; k < ns; k++) begin
            if (stall && k > 0) begin
                cs_hi();
                cs_lo();
            end
            send_byte(dat(k, s, lsb), lsb);
        end
        cs_hi();
        if (stall) chk("R8 paused write count", wn - base, nb);
        else       chk("R7 write count", wn - base, nb);
        for (int k = 0; k < nb; k++) begin
            chk(lsb ? "R5 write addr" : "R4 write addr", wa[(base + k) % 256], ea(s, k, lsb));
            chk("R2 write data", wd[(base + k) % 256], dat(k, s, lsb));
        end
    endtask

    task automatic do_read(input logic [12:0] s, input int len, input logic lsb, input bit stall);
        int nb, ns, base, wbase;
        logic [7:0] v;
        nb = (len == 3) ? 5 : len + 1;
        ns = (stall || len == 3) ? nb : nb + 1;
        base = rn;
        wbase = wn;
        cs_lo();
        send_instr({1'b1, 2'(len), s}, lsb);
        for (int k = 0; k < ns; k++) begin
            if (stall && k > 0) begin
                cs_hi();
                cs_lo();
            end
            recv_byte(lsb, v);
            if (k < nb) begin
                chk(lsb ? "R5 read byte" : "R4 read byte", v, pat(ea(s, k, lsb)));
                chk("R3 sdo_oe in read phase", oe_s, 1);
            end else begin
                chk("R7 sdo_oe after last byte", oe_s, 0);
                chk("R7 sdo quiet after last byte", v, 0);
            end
        end
        cs_hi();
        chk("R1 read gives no write", wn - wbase, 0);
        if (len == 3) chk("R7 stream read count", (rn - base >= nb) ? 1 : 0, 1);
        else          chk(stall ? "R8 paused read count" : "R7 read count", rn - base, nb);
        for (int k = 0; k < nb; k++)
            chk("R3 read addr", ra[(base + k) % 256], ea(s, k, lsb));
    endtask

    initial begin
        logic r;
        int base, e0;
        logic [12:0] starts [2];

        wait_clk(3);
        chk("R10 reg_wr in reset", reg_wr, 0);
        chk("R10 reg_rd in reset", reg_rd, 0);
        chk("R10 sdo_oe in reset", sdo_oe, 0);
        chk("R10 sdo in reset", sdo, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk("R10 sdo_oe after reset", sdo_oe, 0);

        // MSB-first sweeps; start 1 wraps past 0x0000.
        starts[0] = 13'h0001;
        starts[1] = 13'h0ABC;
        for (int si = 0; si < 2; si++)
            for (int len = 0; len < 4; len++) do_write(starts[si], len, 1'b0, 1'b0);
        for (int si = 0; si < 2; si++)
            for (int len = 0; len < 4; len++) do_read(starts[si], len, 1'b0, 1'b0);

        // Paused transfers
        do_write(13'h0321, 2, 1'b0, 1'b1);
        do_read(13'h0777, 1, 1'b0, 1'b1);

        // Abort in a data byte: one full byte, then three bits
        base = wn;
        cs_lo();
        send_instr({1'b0, 2'd2, 13'h0200}, 1'b0);
        send_byte(8'h81, 1'b0);
        for (int i = 0; i < 3; i++) xbit(1'b1, r);
        cs_hi();
        chk("R9 partial byte gives no strobe", wn - base, 1);
        do_write(13'h0123, 0, 1'b0, 1'b0);

        // Abort inside the instruction
        cs_lo();
        for (int i = 0; i < 5; i++) xbit(1'b1, r);
        cs_hi();
        base = wn;
        do_write(13'h0456, 0, 1'b0, 1'b0);
        chk("R9 port back to instruction phase", wn - base, 1);

        // Mode switch in mid-stream takes effect only at the next instruction
        base = wn;
        cs_lo();
        send_instr({1'b0, 2'd3, 13'h0001}, 1'b0);
        send_byte(8'h11, 1'b0);
        send_byte(8'h40, 1'b0);
        send_byte(8'h22, 1'b0);
        cs_hi();
        chk("R6 stream count", wn - base, 3);
        chk("R6 addr 0 reached", wa[(base + 1) % 256], 13'h0000);
        chk("R6 still decrementing", wa[(base + 2) % 256], 13'h1FFF);
        chk("R6 still msb order", wd[(base + 2) % 256], 8'h22);

        // LSB-first sweeps; start 0x1FFE wraps past 0x1FFF.
        starts[0] = 13'h1FFE;
        e0 = errors;
        for (int si = 0; si < 2; si++)
            for (int len = 0; len < 4; len++) do_write(starts[si], len, 1'b1, 1'b0);
        chk("R6 lsb mode active", errors - e0, 0);
        for (int si = 0; si < 2; si++)
            for (int len = 0; len < 4; len++) do_read(starts[si], len, 1'b1, 1'b0);
        do_write(13'h0AAA, 2, 1'b1, 1'b1);

        // Same-cycle last edge and release, clearing the mode bit
        base = wn;
        cs_lo();
        send_instr({1'b0, 2'd0, 13'h0000}, 1'b1);
        send_byte_end(8'h00, 1'b1);
        chk("R8 same-cycle end strobe count", wn - base, 1);
        chk("R8 same-cycle end addr", wa[base % 256], 13'h0000);
        chk("R8 same-cycle end data", wd[base % 256], 8'h00);
        e0 = errors;
        do_write(13'h0100, 1, 1'b0, 1'b0);
        do_read(13'h0000, 1, 1'b0, 1'b0);
        chk("R6 msb mode restored", errors - e0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule